// File: doc/BRIEF.md
# Nonvolatile Byte Array Program/Erase Sequencer

This block sits in front of a small byte-wide nonvolatile array and its configuration word. The array and the configuration word are held here as behavioural models. Software drives three kinds of write into it:

- control-register writes, carrying erase, latch and voltage-enable bits;
- array writes, carrying an address and a data byte;
- configuration writes, carrying a data byte.

The programming voltage turns on only after a fixed three-step write order. A modelled charge-pump counter then runs for a fixed number of pump ticks. When the count is done, the block changes the latched byte once.

A program operation clears bits only: the new value is the old value ANDed with the written data. An erase operation sets the byte to 0xFF. Section protect flags and a separate configuration protect flag can block the change.

While the latch bit is clear, the array acts as plain read-only memory. Bit 0 of the configuration word gates every read. A select input picks the pump clock: either every bus clock cycle, or the cycles that carry a pulse from a second, slower oscillator.

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset, the control readback `ctl_rdata` (bit2 erase, bit1 latch, bit0 voltage enable) is 0, `busy` and `done` are low, every array byte and the configuration word read 0xFF, and `rd_hit` is high.
- R2: A completed program operation stores the bitwise AND of the old byte and the latched data byte.
- R3: A completed operation with the erase bit set stores 0xFF, whatever the data.
- R4: While the latch bit is 0, array writes leave the array unchanged.
- R5: A control write that sets latch and voltage enable together while latch is 0 leaves both bits 0.
- R6: Voltage enable becomes 1 only on a control write of latch=1 and enable=1. That write must come after a write with latch=1 and enable=0, and after an array or configuration write. Otherwise voltage enable stays 0.
- R7: No byte changes when the protect flag of its section is set. The section is given by the top `$clog2(SECT_N)` address bits. A configuration-word operation is likewise blocked while `cfg_lock` is high.
- R8: When bit 0 of the configuration word is 0, `rd_hit` is low and `rd_data` is 0x00.
- R9: While voltage enable is set, `busy` is high, a visible read returns 0xFF, and array or configuration writes do not change the latched address or data.
- R10: The change is applied on the PROG_CYCLES-th pump tick after the enabling write, and `done` rises with it. Clearing voltage enable earlier aborts with no change and drops the armed state.
- R11: With `pump_sel`=0 every clock cycle is a pump tick. With `pump_sel`=1 only cycles with `rc_tick` high count.
- R12: A control write with latch=0 returns to idle and discards the latched write. A later enable write then needs a fresh array or configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | {erase, latch, voltage enable} |
| ctl_rdata | output | 3 | Control register readback |
| arr_we | input | 1 | Array write strobe |
| arr_addr | input | ADDR_W | Array write address |
| arr_wdata | input | 8 | Array write data |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| sect_lock | input | SECT_N | Per-section protect flags |
| cfg_lock | input | 1 | Configuration word protect flag |
| pump_sel | input | 1 | Pump clock select: 0 bus clock, 1 RC tick |
| rc_tick | input | 1 | RC oscillator tick enable |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data |
| rd_hit | output | 1 | Array visible to reads |
| cfg_word | output | 8 | Configuration word contents |
| busy | output | 1 | Programming voltage enabled |
| done | output | 1 | Timed operation finished, voltage still on |

## Verification
Random program operations use random addresses, data, erase choices and section locks. Each result is compared with a model byte, which tells AND-merging apart from overwrite, from erase, and from a blocked section.

Directed sequences follow:
- the joint latch-and-enable write;
- an enable write with no data write;
- an enable write after the latch was dropped;
- an early abort;
- a stalled RC tick.

Each of these separates a sequencer that enforces the step order and the tick count from one that only looks at the final control value. A configuration-word program and erase shows how visibility gates reads.

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq #(
  parameter int ADDR_W      = 5,
  parameter int SECT_N      = 4,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  output logic [2:0]        ctl_rdata,
  input  logic              arr_we,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [7:0]        arr_wdata,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic [SECT_N-1:0] sect_lock,
  input  logic              cfg_lock,
  input  logic              pump_sel,
  input  logic              rc_tick,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_hit,
  output logic [7:0]        cfg_word,
  output logic              busy,
  output logic              done
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SECT_W = $clog2(SECT_N);
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  logic              erase_q, latch_q, pgm_q, armed_q, tgt_cfg_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [7:0]        lat_data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        cfg_q;

  wire pump_tick = pump_sel ? rc_tick : 1'b1;
  wire joint     = ctl_wdata[1] & ctl_wdata[0] & ~latch_q;
  wire pgm_ok    = ctl_wdata[1] & ctl_wdata[0] & latch_q & armed_q;
  wire arm_wr    = latch_q & ~pgm_q & (arr_we | cfg_we);
  wire locked    = tgt_cfg_q ? cfg_lock : sect_lock[lat_addr_q[ADDR_W-1 -: SECT_W]];
  wire fire      = pgm_q & (cnt_q == CNT_W'(1)) & pump_tick;
  wire [7:0] old_val = tgt_cfg_q ? cfg_q : mem[lat_addr_q];
  wire [7:0] new_val = erase_q ? 8'hFF : (old_val & lat_data_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q    <= 1'b0;
      latch_q    <= 1'b0;
      pgm_q      <= 1'b0;
      armed_q    <= 1'b0;
      tgt_cfg_q  <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= 8'hFF;
    end else if (ctl_we) begin
      erase_q <= ctl_wdata[2];
      if (!ctl_wdata[1] || joint) begin
        latch_q <= 1'b0;
        pgm_q   <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        latch_q <= 1'b1;
        pgm_q   <= pgm_ok;
        if (pgm_q && !ctl_wdata[0]) armed_q <= 1'b0;
      end
    end else if (arm_wr) begin
      armed_q    <= 1'b1;
      tgt_cfg_q  <= cfg_we;
      lat_data_q <= cfg_we ? cfg_wdata : arr_wdata;
      if (!cfg_we) lat_addr_q <= arr_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    cnt_q <= '0;
    else if (ctl_we && pgm_ok && !pgm_q)           cnt_q <= CNT_W'(PROG_CYCLES);
    else if (pgm_q && cnt_q != '0 && pump_tick)    cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      cfg_q <= 8'hFF;
    end else if (fire && !locked) begin
      if (tgt_cfg_q) cfg_q <= new_val;
      else           mem[lat_addr_q] <= new_val;
    end
  end

  assign ctl_rdata = {erase_q, latch_q, pgm_q};
  assign busy      = pgm_q;
  assign done      = pgm_q & (cnt_q == '0);
  assign cfg_word  = cfg_q;
  assign rd_hit    = cfg_q[0];
  assign rd_data   = !cfg_q[0] ? 8'h00 : (pgm_q ? 8'hFF : mem[rd_addr]);

  a_r5_no_joint_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !latch_q && ctl_wdata[1] && ctl_wdata[0]) |=> (!latch_q && !pgm_q));

  a_r6_enable_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_q) |-> ($past(latch_q) && $past(armed_q) && $past(ctl_we)));

  a_r9_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_q |=> (!pgm_q || ($stable(lat_addr_q) && $stable(lat_data_q))));

  a_r12_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[1]) |=> (!armed_q && !pgm_q && !busy));

  a_r10_done_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

// File: tb/sim_nvm_prog_seq.sv
module sim_nvm_prog_seq;
  localparam int AW = 5;
  localparam int SN = 4;
  localparam int N  = 8;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0; logic [2:0] ctl_wdata = 0; logic [2:0] ctl_rdata;
  logic arr_we = 0; logic [AW-1:0] arr_addr = 0; logic [7:0] arr_wdata = 0;
  logic cfg_we = 0; logic [7:0] cfg_wdata = 0;
  logic [SN-1:0] sect_lock = 0; logic cfg_lock = 0;
  logic pump_sel = 0, rc_tick = 0;
  logic [AW-1:0] rd_addr = 0; logic [7:0] rd_data; logic rd_hit;
  logic [7:0] cfg_word; logic busy, done;

  int vec = 0, miss = 0;
  logic [7:0] model [1<<AW];

  always #2.5 clk = ~clk;

  nvm_prog_seq #(.ADDR_W(AW), .SECT_N(SN), .PROG_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .sect_lock(sect_lock), .cfg_lock(cfg_lock), .pump_sel(pump_sel),
    .rc_tick(rc_tick), .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit),
    .cfg_word(cfg_word), .busy(busy), .done(done));

  function automatic logic [7:0] f_prog(input logic [7:0] old, input logic [7:0] d,
                                        input logic er, input logic lk);
    return lk ? old : (er ? 8'hFF : (old & d));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl_wr(input logic [2:0] v);
    ctl_we = 1; ctl_wdata = v; @(negedge clk); ctl_we = 0;
  endtask
  task automatic arr_wr(input logic [AW-1:0] a, input logic [7:0] d);
    arr_we = 1; arr_addr = a; arr_wdata = d; @(negedge clk); arr_we = 0;
  endtask
  task automatic cfg_wr(input logic [7:0] d);
    cfg_we = 1; cfg_wdata = d; @(negedge clk); cfg_we = 0;
  endtask
  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic do_prog(input logic to_cfg, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic er);
    logic lk;
    lk = to_cfg ? cfg_lock : sect_lock[a[AW-1 -: 2]];
    ctl_wr({er, 2'b10});
    if (to_cfg) cfg_wr(d); else arr_wr(a, d);
    ctl_wr({er, 2'b11});
    chk("R9 busy", busy, 1);
    repeat (N) @(negedge clk);
    chk("R10 done", done, 1);
    ctl_wr({er, 2'b10});
    ctl_wr(3'b000);
    if (!to_cfg) model[a] = f_prog(model[a], d, er, lk);
  endtask

  initial begin
    #(100000 * 5);
    miss++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED1));
    for (int i = 0; i < (1<<AW); i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk("R1 ctl", ctl_rdata, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 cfg", cfg_word, 8'hFF);
    chk("R1 hit", rd_hit, 1);
    rd(5'd17, r); chk("R1 erased", r, 8'hFF);

    ctl_wr(3'b011);
    chk("R5 joint set", ctl_rdata, 3'b000);

    arr_wr(5'd3, 8'h00);
    rd(5'd3, r); chk("R4 rom write", r, 8'hFF);

    ctl_wr(3'b010);
    ctl_wr(3'b011);
    chk("R6 no data write", ctl_rdata, 3'b010);
    ctl_wr(3'b000);

    ctl_wr(3'b010);
    arr_wr(5'd5, 8'h0F);
    ctl_wr(3'b011);
    chk("R9 busy", busy, 1);
    rd(5'd4, r); chk("R9 read ff", r, 8'hFF);
    arr_wr(5'd6, 8'h00);
    repeat (N-2) @(negedge clk);
    chk("R10 early done", done, 0);
    @(negedge clk);
    chk("R10 done", done, 1);
    ctl_wr(3'b010); ctl_wr(3'b000);
    rd(5'd5, r); chk("R2 and", r, 8'h0F);
    rd(5'd6, r); chk("R9 write ignored", r, 8'hFF);
    model[5] = 8'h0F;

    ctl_wr(3'b010);
    arr_wr(5'd7, 8'h00);
    ctl_wr(3'b011);
    repeat (3) @(negedge clk);
    ctl_wr(3'b010);
    chk("R10 abort busy", busy, 0);
    rd(5'd7, r); chk("R10 abort", r, 8'hFF);
    ctl_wr(3'b011);
    chk("R10 disarmed", ctl_rdata, 3'b010);
    ctl_wr(3'b000);

    ctl_wr(3'b010);
    arr_wr(5'd8, 8'h00);
    ctl_wr(3'b000);
    ctl_wr(3'b010);
    ctl_wr(3'b011);
    chk("R12 discard", ctl_rdata, 3'b010);
    ctl_wr(3'b000);
    rd(5'd8, r); chk("R12 unchanged", r, 8'hFF);

    do_prog(1'b0, 5'd5, 8'h00, 1'b1);
    rd(5'd5, r); chk("R3 erase", r, 8'hFF);

    pump_sel = 1; rc_tick = 0;
    ctl_wr(3'b010);
    arr_wr(5'd9, 8'h55);
    ctl_wr(3'b011);
    repeat (N+3) @(negedge clk);
    chk("R11 stalled", done, 0);
    rc_tick = 1;
    repeat (N-1) @(negedge clk);
    chk("R11 one short", done, 0);
    @(negedge clk);
    chk("R11 ticked", done, 1);
    ctl_wr(3'b010); ctl_wr(3'b000);
    pump_sel = 0; rc_tick = 0;
    rd(5'd9, r); chk("R11 data", r, 8'h55);
    model[9] = 8'h55;

    cfg_lock = 1;
    do_prog(1'b1, 0, 8'h00, 1'b0);
    chk("R7 cfg locked", cfg_word, 8'hFF);
    cfg_lock = 0;
    do_prog(1'b1, 0, 8'hFE, 1'b0);
    chk("R8 cfg", cfg_word, 8'hFE);
    chk("R8 hit", rd_hit, 0);
    rd(5'd9, r); chk("R8 data", r, 8'h00);
    do_prog(1'b1, 0, 8'h00, 1'b1);
    chk("R8 visible again", rd_hit, 1);

    for (int i = 0; i < 150; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      logic er;
      a = AW'($urandom);
      d = 8'($urandom);
      er = ($urandom % 4) == 0;
      sect_lock = SN'($urandom);
      do_prog(1'b0, a, d, er);
      rd(a, r);
      if (er) chk("R3 random", r, model[a]);
      else if (sect_lock[a[AW-1 -: 2]]) chk("R7 random", r, model[a]);
      else chk("R2 random", r, model[a]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule